// File: doc/BRIEF.md
# Retention Mode Unlock Sequence Detector

This block sits beside the access controller of a pseudo-static memory. It watches each completed access to the array and looks for a fixed six-step unlock pattern. That pattern picks which part of the array keeps its contents the next time the chip-enable pin that controls power-down is pulled low. Each access event the controller reports carries four things: whether it was a read or a write, its full word address, which byte lanes were enabled, and whether the device was in standby before the access.

The block drives three things. The first is the retention mode now in force, together with the top address that the mode retains. The second is a per-write commit flag: it tells the array whether the write it is completing should be stored, or dropped because it fell inside the part of the pattern whose data does not matter. The third is a pair of one-clock pulses: one when the pattern completes with a legal key, one when it ends on an illegal key.

Top module: `retention_seq_detect`

## Requirements
- R1: After reset the mode is sleep (ret_mode = 0), ret_keep is 0, ret_top is 0, and prog_done and key_err are low.
- R2: The pattern is a read at the all-ones address, four writes at the all-ones address, then a key read, with acc_after_standby high on steps 2 to 6. A key of all ones with the two top bits at 10 (17FFFFh) selects the small partial mode (ret_mode = 1, ret_keep = 1, ret_top = 3FFFFh).
- R3: A key whose two top bits are 01 and whose other bits are all ones (0FFFFFh) selects the large partial mode (ret_mode = 2, ret_keep = 1, ret_top = 7FFFFh).
- R4: A key of all ones (1FFFFFh) selects sleep, which retains nothing (ret_mode = 0, ret_keep = 0, ret_top = 0).
- R5: A key read at any other address leaves the mode unchanged. It raises key_err for one clock and does not raise prog_done.
- R6: A write at another address in place of step 2 or 3 cancels the pattern, and wr_commit is 1 for that write. The step 2 and 3 writes at the all-ones address also have wr_commit = 1.
- R7: Any write that arrives while step 4 or step 5 is expected has wr_commit = 0. A write at another address there also cancels the pattern.
- R8: An access in steps 2 to 6 without acc_after_standby cancels the pattern.
- R9: A read at an address other than all ones while a write step is expected returns the tracker to idle. A read at the all-ones address in any step from 2 to 6 that does not complete the pattern counts as a new step 1.
- R10: An access with only one lane bit set in acc_lanes counts as a step. An event with acc_lanes = 00 is ignored.
- R11: prog_done is high for exactly the one clock after the accepted key read, and the mode outputs change in that same clock. wr_commit is 0 when there is no write event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One completed access reported this cycle |
| acc_is_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_lanes | input | 2 | Byte lanes enabled, active high |
| acc_after_standby | input | 1 | Device was in standby before this access |
| wr_commit | output | 1 | The array should store the write reported this cycle |
| ret_mode | output | 2 | 0 sleep, 1 small partial, 2 large partial |
| ret_keep | output | 1 | Some range is retained in power-down |
| ret_top | output | ADDR_W | Highest retained address |
| prog_done | output | 1 | One-clock pulse: pattern accepted |
| key_err | output | 1 | One-clock pulse: illegal key |

## Verification
On every cycle the assertions check these rules: the mode changes only together with prog_done; an error pulse leaves the mode where it was; the two pulses never coincide; wr_commit appears only with a write event; sleep never reports a retained range. How the pattern gets cancelled can only be shown by the bench's scenarios: by address, by missing standby, by a stray read, or by a read that restarts it. The same holds for commit versus drop of the early and late writes, and for the byte-lane cases, because each depends on a whole multi-access history.

// File: rtl/retention_pkg.sv
package retention_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_SMALL = 2'd1,
    MODE_LARGE = 2'd2
  } ret_mode_e;

  typedef enum logic [2:0] {
    TRK_IDLE = 3'd0,
    TRK_W2   = 3'd1,
    TRK_W3   = 3'd2,
    TRK_W4   = 3'd3,
    TRK_W5   = 3'd4,
    TRK_KEY  = 3'd5
  } trk_state_e;
endpackage

// File: rtl/retention_key_decode.sv
module retention_key_decode #(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic                      is_all_ones,
  output logic                      key_legal,
  output retention_pkg::ret_mode_e  key_mode
);
  import retention_pkg::*;

  localparam int LOW_W = ADDR_W - 2;

  logic       low_ones;
  logic [1:0] top2;

  always_comb begin
    low_ones    = &addr[LOW_W-1:0];
    top2        = addr[ADDR_W-1:ADDR_W-2];
    is_all_ones = low_ones && (top2 == 2'b11);
    key_legal   = 1'b0;
    key_mode    = MODE_SLEEP;
    if (low_ones) begin
      case (top2)
        2'b11: begin key_legal = 1'b1; key_mode = MODE_SLEEP; end
        2'b10: begin key_legal = 1'b1; key_mode = MODE_SMALL; end
        2'b01: begin key_legal = 1'b1; key_mode = MODE_LARGE; end
        default: begin key_legal = 1'b0; key_mode = MODE_SLEEP; end
      endcase
    end
  end
endmodule

// File: rtl/retention_seq_tracker.sv
module retention_seq_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic ev_write,
  input  logic ev_standby,
  input  logic ev_all_ones,
  output logic key_fire,
  output logic commit
);
  import retention_pkg::*;

  trk_state_e st_q, st_d;

  function automatic trk_state_e step_after(input trk_state_e s);
    case (s)
      TRK_W2:  step_after = TRK_W3;
      TRK_W3:  step_after = TRK_W4;
      TRK_W4:  step_after = TRK_W5;
      TRK_W5:  step_after = TRK_KEY;
      default: step_after = TRK_IDLE;
    endcase
  endfunction

  always_comb begin
    st_d     = st_q;
    key_fire = 1'b0;
    if (ev) begin
      case (st_q)
        TRK_IDLE: begin
          if (!ev_write && ev_all_ones) st_d = TRK_W2;
        end
        TRK_W2, TRK_W3, TRK_W4, TRK_W5: begin
          if (!ev_write)
            st_d = ev_all_ones ? TRK_W2 : TRK_IDLE;
          else if (!ev_standby || !ev_all_ones)
            st_d = TRK_IDLE;
          else
            st_d = step_after(st_q);
        end
        TRK_KEY: begin
          if (!ev_write && ev_standby) begin
            key_fire = 1'b1;
            st_d     = TRK_IDLE;
          end else if (!ev_write) begin
            st_d = ev_all_ones ? TRK_W2 : TRK_IDLE;
          end else begin
            st_d = TRK_IDLE;
          end
        end
        default: st_d = TRK_IDLE;
      endcase
    end
  end

  always_comb begin
    commit = ev && ev_write && !(st_q == TRK_W4 || st_q == TRK_W5);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TRK_IDLE;
    else if (ev) st_q <= st_d;
  end
endmodule

// File: rtl/retention_mode_reg.sv
module retention_mode_reg #(
  parameter int ADDR_W = 21
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_fire,
  input  logic                      key_legal,
  input  retention_pkg::ret_mode_e  key_mode,
  output retention_pkg::ret_mode_e  mode,
  output logic [ADDR_W-1:0]         top,
  output logic                      done,
  output logic                      err
);
  import retention_pkg::*;

  localparam logic [ADDR_W-1:0] TOP_SMALL = ADDR_W'((64'd1 << (ADDR_W - 3)) - 64'd1);
  localparam logic [ADDR_W-1:0] TOP_LARGE = ADDR_W'((64'd1 << (ADDR_W - 2)) - 64'd1);

  ret_mode_e mode_q, mode_d;
  logic      done_q, done_d, err_q, err_d, mode_en;

  always_comb begin
    mode_en = key_fire && key_legal;
    mode_d  = mode_en ? key_mode : mode_q;
    done_d  = mode_en;
    err_d   = key_fire && !key_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    case (mode_q)
      MODE_SMALL: top = TOP_SMALL;
      MODE_LARGE: top = TOP_LARGE;
      default:    top = '0;
    endcase
  end

  assign mode = mode_q;
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/retention_seq_detect.sv
module retention_seq_detect #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_lanes,
  input  logic              acc_after_standby,
  output logic              wr_commit,
  output logic [1:0]        ret_mode,
  output logic              ret_keep,
  output logic [ADDR_W-1:0] ret_top,
  output logic              prog_done,
  output logic              key_err
);
  import retention_pkg::*;

  logic      ev, all_ones, key_legal, key_fire;
  ret_mode_e key_mode, mode;

  assign ev = acc_valid && (|acc_lanes);

  retention_key_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr        (acc_addr),
    .is_all_ones (all_ones),
    .key_legal   (key_legal),
    .key_mode    (key_mode)
  );

  retention_seq_tracker u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev),
    .ev_write    (acc_is_write),
    .ev_standby  (acc_after_standby),
    .ev_all_ones (all_ones),
    .key_fire    (key_fire),
    .commit      (wr_commit)
  );

  retention_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_fire  (key_fire),
    .key_legal (key_legal),
    .key_mode  (key_mode),
    .mode      (mode),
    .top       (ret_top),
    .done      (prog_done),
    .err       (key_err)
  );

  assign ret_mode = mode;
  assign ret_keep = (mode != MODE_SLEEP);
endmodule

// File: rtl/retention_seq_detect_chk.sv
module retention_seq_detect_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_is_write,
  input logic              wr_commit,
  input logic [1:0]        ret_mode,
  input logic              ret_keep,
  input logic [ADDR_W-1:0] ret_top,
  input logic              prog_done,
  input logic              key_err
);
  // R11
  mode_moves_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_mode != $past(ret_mode)) |-> prog_done);
  // R5
  err_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |-> (ret_mode == $past(ret_mode)));
  // R5
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_done && key_err));
  // R11
  commit_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (acc_valid && acc_is_write));
  // R4
  sleep_keeps_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_mode == 2'd0) |-> (!ret_keep && ret_top == '0));
  // R11
  done_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> $past(acc_valid && !acc_is_write));
  // R1
  legal_mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_mode != 2'd3);
endmodule

bind retention_seq_detect retention_seq_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_is_write (acc_is_write),
  .wr_commit    (wr_commit),
  .ret_mode     (ret_mode),
  .ret_keep     (ret_keep),
  .ret_top      (ret_top),
  .prog_done    (prog_done),
  .key_err      (key_err)
);

// File: tb/retention_seq_detect_test.sv
module retention_seq_detect_test;
  localparam int ADDR_W = 21;
  localparam time CLK_PERIOD = 10;
  localparam logic [20:0] ONES  = 21'h1FFFFF;
  localparam logic [20:0] K_SML = 21'h17FFFF;
  localparam logic [20:0] K_LRG = 21'h0FFFFF;

  logic clk, rst_n, acc_valid, acc_is_write, acc_after_standby;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0] acc_lanes;
  logic wr_commit, ret_keep, prog_done, key_err;
  logic [1:0] ret_mode;
  logic [ADDR_W-1:0] ret_top;

  int total = 0;
  int bad = 0;
  logic last_commit;

  retention_seq_detect #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_write(acc_is_write),
    .acc_addr(acc_addr), .acc_lanes(acc_lanes), .acc_after_standby(acc_after_standby),
    .wr_commit(wr_commit), .ret_mode(ret_mode), .ret_keep(ret_keep), .ret_top(ret_top),
    .prog_done(prog_done), .key_err(key_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: driven at negedge, commit sampled before the edge, outputs read at next negedge
  task automatic acc(input logic wr, input logic [20:0] a, input logic sb, input logic [1:0] ln);
    @(negedge clk);
    acc_valid = 1'b1; acc_is_write = wr; acc_addr = a;
    acc_after_standby = sb; acc_lanes = ln;
    #1 last_commit = wr_commit;
    @(negedge clk);
    acc_valid = 1'b0; acc_is_write = 1'b0; acc_lanes = 2'b00;
  endtask

  task automatic five_steps();
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 mode", ret_mode, 2'd0);
    check("R1 keep", ret_keep, 1'b0);
    check("R1 top", ret_top, 0);
    check("R1 done", prog_done, 1'b0);
    check("R1 err", key_err, 1'b0);
  endtask

  task automatic t_small();
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11); check("R6 step2 commit", last_commit, 1'b1);
    acc(1'b1, ONES, 1'b1, 2'b11); check("R6 step3 commit", last_commit, 1'b1);
    acc(1'b1, ONES, 1'b1, 2'b11); check("R7 step4 drop", last_commit, 1'b0);
    acc(1'b1, ONES, 1'b1, 2'b11); check("R7 step5 drop", last_commit, 1'b0);
    acc(1'b0, K_SML, 1'b1, 2'b11);
    check("R2 done", prog_done, 1'b1);
    check("R2 mode", ret_mode, 2'd1);
    check("R2 keep", ret_keep, 1'b1);
    check("R2 top", ret_top, 21'h3FFFF);
    idle_cycle();
    check("R11 done one clock", prog_done, 1'b0);
    check("R11 no write commit", wr_commit, 1'b0);
  endtask

  task automatic t_large_bytes();
    // R10: single-lane accesses count, empty-lane events ignored
    acc(1'b0, ONES, 1'b1, 2'b01);
    acc(1'b1, 21'h000123, 1'b0, 2'b00);
    acc(1'b1, ONES, 1'b1, 2'b10);
    acc(1'b1, ONES, 1'b1, 2'b01);
    acc(1'b1, ONES, 1'b1, 2'b10);
    acc(1'b1, ONES, 1'b1, 2'b01);
    acc(1'b0, K_LRG, 1'b1, 2'b10);
    check("R10 R3 done", prog_done, 1'b1);
    check("R3 mode", ret_mode, 2'd2);
    check("R3 top", ret_top, 21'h7FFFF);
  endtask

  task automatic t_bad_key();
    five_steps();
    acc(1'b0, 21'h07FFFF, 1'b1, 2'b11);
    check("R5 err", key_err, 1'b1);
    check("R5 no done", prog_done, 1'b0);
    check("R5 mode kept", ret_mode, 2'd2);
    idle_cycle();
    check("R5 err one clock", key_err, 1'b0);
  endtask

  task automatic t_early_cancel();
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, 21'h000040, 1'b1, 2'b11);
    check("R6 cancel write commit", last_commit, 1'b1);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b0, K_SML, 1'b1, 2'b11);
    check("R6 no done", prog_done, 1'b0);
    check("R6 mode kept", ret_mode, 2'd2);
  endtask

  task automatic t_late_cancel();
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, 21'h000007, 1'b1, 2'b11);
    check("R7 cancel write dropped", last_commit, 1'b0);
    acc(1'b1, ONES, 1'b1, 2'b11);
    check("R7 after cancel commits", last_commit, 1'b1);
    acc(1'b0, K_SML, 1'b1, 2'b11);
    check("R7 no done", prog_done, 1'b0);
    check("R7 mode kept", ret_mode, 2'd2);
  endtask

  task automatic t_no_standby();
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b0, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b0, K_SML, 1'b1, 2'b11);
    check("R8 no done", prog_done, 1'b0);
    check("R8 mode kept", ret_mode, 2'd2);
  endtask

  task automatic t_stray_read();
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b0, 21'h000100, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b0, K_SML, 1'b1, 2'b11);
    check("R9 stray read cancels", prog_done, 1'b0);
    // restart: read at all ones mid-pattern begins anew
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b0, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b1, ONES, 1'b1, 2'b11);
    acc(1'b0, K_SML, 1'b1, 2'b11);
    check("R9 restart done", prog_done, 1'b1);
    check("R9 restart mode", ret_mode, 2'd1);
  endtask

  task automatic t_sleep();
    five_steps();
    acc(1'b0, ONES, 1'b1, 2'b11);
    check("R4 done", prog_done, 1'b1);
    check("R4 mode", ret_mode, 2'd0);
    check("R4 keep", ret_keep, 1'b0);
    check("R4 top", ret_top, 0);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_is_write = 1'b0; acc_addr = '0;
    acc_lanes = 2'b00; acc_after_standby = 1'b0; last_commit = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_small();
    t_large_bytes();
    t_bad_key();
    t_early_cancel();
    t_late_cancel();
    t_no_standby();
    t_stray_read();
    t_sleep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule